// File: doc/BRIEF.md
# Deferred Snoop Invalidation Queue

This block sits between a coherence snooping bus and the tag array of one private cache. The bus delivers invalidation messages, each naming a line address. While the cache is occupied with its own core's requests, the tag port has no spare cycle, so the block parks those messages in an ordered queue. It then replays them onto the tag invalidate port, one per cycle, in any cycle where the cache reports it is free.

A load may see a stale line while its invalidation is still parked in the queue. This is permitted. A core that needs an ordering point raises the barrier request. The block acknowledges the barrier only once nothing is parked and nothing is being written to the tags in that cycle. When every slot is taken, the block withholds its ready signal toward the bus, so no message is ever lost.

Top module: `inval_defer_q`

## Requirements
- R1: While reset is held low, the invalidate port is idle, bus ready is high, and the barrier acknowledge follows the barrier request.
- R2: No invalidation is driven to the tags in a cycle where the tag-busy input is high. A message accepted in such a cycle is kept for later.
- R3: In every cycle where tag-busy is low and at least one message is queued, exactly one queued message is driven to the tags.
- R4: Invalidations reach the tags in the order the bus handed them over, each exactly once. Nothing is driven that was not received.
- R5: A message accepted in a cycle where tag-busy is low and the queue is empty is driven to the tags in that same cycle, with the same address.
- R6: Bus ready is low exactly when DEPTH messages are queued. A message offered while ready is low is not taken, and every taken message is eventually applied.
- R7: With the barrier request high, the acknowledge is high in exactly those cycles where the queue is empty and no invalidation is being driven.
- R8: The barrier acknowledge is low whenever the barrier request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snp_valid_i | input | 1 | Bus offers an invalidation message |
| snp_addr_i | input | AW | Line address of the offered message |
| snp_ready_o | output | 1 | Block can take a message this cycle |
| tag_busy_i | input | 1 | Tag port is taken by core traffic this cycle |
| inv_valid_o | output | 1 | Invalidate the line named by inv_addr_o |
| inv_addr_o | output | AW | Line address being invalidated |
| fence_req_i | input | 1 | Barrier waiting for all invalidations to finish |
| fence_ack_o | output | 1 | Barrier may complete |

## Verification
The bench keeps a reference queue of the accepted addresses. It checks every tag write against the head of that queue, so a design that reordered or repeated entries, or dropped a message on a simultaneous push and pop, shows up as an address mismatch. It targets the same-cycle bypass on an idle, empty queue: a design that always took the extra queue hop would show a missing write in the arrival cycle. It also fills the queue while the tags are busy and holds a fifth message against backpressure; a design that overwrote an entry would lose an address, and one that released ready early would admit a message with no slot. Barrier requests are raised while entries are parked and while a bypass is in flight, which catches an acknowledge that ignores the write still in progress.

// File: rtl/dqi_pkg.sv
`timescale 1ns/1ps
package dqi_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_HEAD   = 2'd1,
    SEL_BYPASS = 2'd2
  } dqi_sel_e;
endpackage

// File: rtl/dqi_fifo.sv
`timescale 1ns/1ps
module dqi_fifo #(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] data_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [AW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      unique case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL);
endmodule

// File: rtl/dqi_sel.sv
`timescale 1ns/1ps
module dqi_sel
  import dqi_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          busy_i,
  input  logic          empty_i,
  input  logic          in_fire_i,
  input  logic [AW-1:0] in_addr_i,
  input  logic [AW-1:0] head_i,
  output dqi_sel_e      sel_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          inv_valid_o,
  output logic [AW-1:0] inv_addr_o
);
  // Head of queue wins over a new arrival to keep arrival order.
  always_comb begin
    sel_o = SEL_NONE;
    if (!busy_i) begin
      if (!empty_i)       sel_o = SEL_HEAD;
      else if (in_fire_i) sel_o = SEL_BYPASS;
    end
  end

  assign pop_o       = (sel_o == SEL_HEAD);
  assign push_o      = in_fire_i && (sel_o != SEL_BYPASS);
  assign inv_valid_o = (sel_o != SEL_NONE);
  assign inv_addr_o  = (sel_o == SEL_BYPASS) ? in_addr_i : head_i;
endmodule

// File: rtl/dqi_fence.sv
`timescale 1ns/1ps
module dqi_fence (
  input  logic req_i,
  input  logic empty_i,
  input  logic applying_i,
  output logic ack_o
);
  assign ack_o = req_i && empty_i && !applying_i;
endmodule

// File: rtl/inval_defer_q.sv
`timescale 1ns/1ps
module inval_defer_q
  import dqi_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snp_valid_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          snp_ready_o,
  input  logic          tag_busy_i,
  output logic          inv_valid_o,
  output logic [AW-1:0] inv_addr_o,
  input  logic          fence_req_i,
  output logic          fence_ack_o
);
  logic          empty, full, fire, push, pop;
  logic [AW-1:0] head;
  dqi_sel_e      sel;

  assign snp_ready_o = !full;
  assign fire        = snp_valid_i && snp_ready_o;

  dqi_fifo #(.AW(AW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (snp_addr_i),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  dqi_sel #(.AW(AW)) u_sel (
    .busy_i      (tag_busy_i),
    .empty_i     (empty),
    .in_fire_i   (fire),
    .in_addr_i   (snp_addr_i),
    .head_i      (head),
    .sel_o       (sel),
    .push_o      (push),
    .pop_o       (pop),
    .inv_valid_o (inv_valid_o),
    .inv_addr_o  (inv_addr_o)
  );

  dqi_fence u_fence (
    .req_i      (fence_req_i),
    .empty_i    (empty),
    .applying_i (inv_valid_o),
    .ack_o      (fence_ack_o)
  );

  logic sel_unused;
  assign sel_unused = ^sel;
endmodule

// File: rtl/dqi_checker.sv
`timescale 1ns/1ps
module dqi_checker #(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          snp_valid_i,
  input logic [AW-1:0] snp_addr_i,
  input logic          snp_ready_o,
  input logic          tag_busy_i,
  input logic          inv_valid_o,
  input logic [AW-1:0] inv_addr_o,
  input logic          fence_req_i,
  input logic          fence_ack_o
);
  localparam int SW = $clog2(DEPTH + 1) + 1;
  localparam logic [SW-1:0] LIM = SW'(DEPTH);

  logic          acc;
  logic [SW-1:0] held_q;

  assign acc = snp_valid_i && snp_ready_o;

  // Shadow count of accepted-but-not-applied messages.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= held_q + SW'(acc) - SW'(inv_valid_o);
  end

  assert_hold_when_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_busy_i |-> !inv_valid_o);
  assert_drain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tag_busy_i && held_q != '0) |-> inv_valid_o);
  assert_no_spurious_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> (held_q != '0 || acc));
  assert_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !tag_busy_i && held_q == '0) |-> (inv_valid_o && inv_addr_o == snp_addr_i));
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q <= LIM);
  assert_backpressure_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_ready_o |-> (held_q == LIM));
  assert_fence_safe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_ack_o |-> (held_q == '0 && !inv_valid_o));
  assert_fence_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_req_i && held_q == '0 && !inv_valid_o) |-> fence_ack_o);
  assert_fence_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fence_req_i |-> !fence_ack_o);
endmodule

bind inval_defer_q dqi_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .snp_valid_i (snp_valid_i),
  .snp_addr_i  (snp_addr_i),
  .snp_ready_o (snp_ready_o),
  .tag_busy_i  (tag_busy_i),
  .inv_valid_o (inv_valid_o),
  .inv_addr_o  (inv_addr_o),
  .fence_req_i (fence_req_i),
  .fence_ack_o (fence_ack_o)
);

// File: tb/sim_inval_defer_q.sv
`timescale 1ns/1ps
module sim_inval_defer_q;
  localparam int AW    = 16;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          busy = 1'b0;
  logic          freq = 1'b0;
  logic          snp_ready_o, inv_valid_o, fence_ack_o;
  logic [AW-1:0] inv_addr_o;

  logic [AW-1:0] exp_q [$];
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  inval_defer_q #(.AW(AW), .DEPTH(DEPTH)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .snp_valid_i (snp_valid),
    .snp_addr_i  (snp_addr),
    .snp_ready_o (snp_ready_o),
    .tag_busy_i  (busy),
    .inv_valid_o (inv_valid_o),
    .inv_addr_o  (inv_addr_o),
    .fence_req_i (freq),
    .fence_ack_o (fence_ack_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor / scoreboard: sample away from the rising edge.
  logic          m_acc, m_exp_inv, m_exp_ack;
  int            m_qs;
  logic [AW-1:0] m_head;
  always @(negedge clk) begin
    if (rst_n) begin
      m_acc     = snp_valid && snp_ready_o;
      m_qs      = exp_q.size();
      m_exp_inv = !busy && (m_qs > 0 || m_acc);
      m_exp_ack = freq && (m_qs == 0) && !m_exp_inv;
      chk(snp_ready_o == (m_qs < DEPTH), "R6", "ready", snp_ready_o, m_qs < DEPTH);
      chk(inv_valid_o == m_exp_inv, busy ? "R2" : (m_qs > 0 ? "R3" : "R5"),
          "inv_valid", inv_valid_o, m_exp_inv);
      chk(fence_ack_o == m_exp_ack, freq ? "R7" : "R8", "fence_ack",
          fence_ack_o, m_exp_ack);
      if (m_acc) exp_q.push_back(snp_addr);
      if (inv_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "spurious inv", inv_addr_o, 0);
        end else begin
          m_head = exp_q.pop_front();
          chk(inv_addr_o == m_head, "R4", "inv_addr order", inv_addr_o, m_head);
        end
      end
    end
  end

  // Driver: tasks start and end 1 ns after a rising edge.
  task automatic send(input logic [AW-1:0] a);
    logic took;
    snp_valid = 1'b1;
    snp_addr  = a;
    do begin
      @(negedge clk);
      took = snp_ready_o;
      @(posedge clk); #1;
    end while (!took);
    snp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic busy_wave(input logic [15:0] pat);
    for (int i = 0; i < 16; i++) begin
      busy = pat[i];
      @(posedge clk); #1;
    end
    busy = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    // R1: reset values
    freq = 1'b1;
    #5;
    chk(snp_ready_o == 1'b1, "R1", "ready in reset", snp_ready_o, 1);
    chk(inv_valid_o == 1'b0, "R1", "inv in reset", inv_valid_o, 0);
    chk(fence_ack_o == 1'b1, "R1", "ack in reset", fence_ack_o, 1);
    freq = 1'b0;
    #1;
    chk(fence_ack_o == 1'b0, "R1", "ack follows req", fence_ack_o, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(2);

    // R5: bypass when idle and empty, back-to-back
    send(16'h1111);
    send(16'h2222);
    idle(2);

    // R2/R3/R4: park while busy, drain in order
    busy = 1'b1;
    send(16'h0a01);
    send(16'h0a02);
    send(16'h0a03);
    idle(2);
    busy = 1'b0;
    idle(5);

    // R6: fill, hold an extra message under backpressure
    busy = 1'b1;
    for (int i = 0; i < DEPTH; i++) send(AW'(16'h0b00 + i));
    fork
      send(16'h0bff);
      begin idle(3); busy = 1'b0; end
    join
    idle(8);

    // R7: barrier waits on parked entries
    busy = 1'b1;
    send(16'h0c01);
    send(16'h0c02);
    freq = 1'b1;
    idle(3);
    busy = 1'b0;
    idle(4);
    // R7: barrier during a bypass write
    send(16'h0c03);
    idle(2);
    freq = 1'b0;

    // R4: traffic against an irregular busy pattern, push and pop together
    fork
      for (int i = 0; i < 10; i++) send(AW'(16'h0d00 + i));
      busy_wave(16'b1011_0110_1101_0011);
    join
    freq = 1'b1;
    idle(20);
    freq = 1'b0;

    // R6: no accepted message lost
    chk(exp_q.size() == 0, "R6", "left undrained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule